// File: doc/BRIEF.md
# Configurable SPI Serial Controller

This block moves one 8-bit frame at a time over a four-wire serial link. A static set of control inputs picks its role. As clock master it makes the serial clock from the system clock through a power-of-two prescaler and drives the master-out data line. As slave it follows an external clock and select line, and it drives the slave-out data line. Data is captured on the first clock edge of each bit period and is moved on the second edge.

A transmit word is handed over with a one-cycle load strobe. In master mode that strobe also starts the frame. In slave mode the word waits until the external master clocks it out. The received word appears with a one-cycle done pulse, and busy covers the frame. Each pad has an output-enable, so a cleared enable means the pad is in high impedance. In receive-only operation the block never enables its data output. Software slave management replaces the select pin with an internal bit. Role, polarity, bit order, receive-only and rate are captured when a frame starts and are held until it ends.

Top module: `spi_frame_engine`

## Requirements
- R1: In master mode with rate code n (br_i, 0 to 7), each half period of sck_o lasts 2^n system clocks, so the serial clock is the system clock divided by 2^(n+1). busy_o is high for exactly 16·2^n cycles per frame.
- R2: With cpol_i = 0 the serial clock rests low between frames, and with cpol_i = 1 it rests high. In master mode while enabled and idle, sck_oe_o is 1 and sck_o equals cpol_i.
- R3: With lsb_first_i = 0, bit 7 is sent and received first. With lsb_first_i = 1, bit 0 comes first. This holds in both roles.
- R4: With rx_only_i = 1 the data output enable (mosi_oe_o as master, miso_oe_o as slave) stays 0 for the whole frame, and reception still completes.
- R5: With ssm_i = 1 the effective select is ssi_i and the nss_i level is ignored: ssi_i = 0 selects the slave, ssi_i = 1 deselects it. With ssm_i = 0, nss_i low selects.
- R6: In slave mode, an effective select going high mid-frame ends the frame with no done pulse. It clears busy_o and miso_oe_o and restarts the bit count, so the next frame receives all 8 bits correctly.
- R7: In master mode a tx_load_i pulse while enabled and not busy starts a frame with tx_data_i. At the trailing edge of the eighth bit, busy_o falls, done_o is high for exactly one cycle and rx_data_o is updated. A load pulse during a frame is ignored.
- R8: Changing role, polarity, bit order or rate during a frame has no effect on that frame.
- R9: With en_i = 0 and no frame running, a load pulse starts nothing and all output enables are 0. Clearing en_i during a frame lets that frame finish normally.
- R10: In slave mode, with the slave selected, 8 external clock periods shift mosi_i into rx_data_o, drive the loaded word on miso_o, and give one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable |
| master_i | input | 1 | 1 = clock master, 0 = slave |
| cpol_i | input | 1 | Serial clock rest level |
| lsb_first_i | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| br_i | input | 3 | Rate code n, divide by 2^(n+1) |
| rx_only_i | input | 1 | 1 = never enable the data output |
| ssm_i | input | 1 | 1 = use ssi_i as the select |
| ssi_i | input | 1 | Internal select level |
| tx_data_i | input | 8 | Word to transmit |
| tx_load_i | input | 1 | One-cycle load strobe |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock pad enable |
| mosi_i | input | 1 | Master-out data in (slave) |
| mosi_o | output | 1 | Master-out data (master) |
| mosi_oe_o | output | 1 | Master-out pad enable |
| miso_i | input | 1 | Slave-out data in (master) |
| miso_o | output | 1 | Slave-out data (slave) |
| miso_oe_o | output | 1 | Slave-out pad enable |
| nss_i | input | 1 | Slave select pin, active low |
| rx_data_o | output | 8 | Last received word |
| done_o | output | 1 | One-cycle frame-complete pulse |
| busy_o | output | 1 | Frame in progress |

## Verification
The assertions check on every cycle that the prescaler count stays within the selected half period, and that done is a single-cycle pulse that falls together with busy. They also check that the captured configuration holds still for the whole frame, that a deselect clears the bit count and busy, and that receive-only never enables a data pad. The bench scenarios show what needs whole frames: the clock rate for each code, the rest level, the bit order on both data lines, the data received in each role, the ignored select pin under software management, recovery after an aborted slave frame, and a frame that completes after enable is dropped.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

    localparam int FRAME_BITS = 8;
    localparam int BR_W       = 3;

    typedef struct packed {
        logic            master;
        logic            cpol;
        logic            lsb_first;
        logic            rx_only;
        logic [BR_W-1:0] br;
    } cfg_t;

    // A clock transition that leaves the rest level opens a bit period.
    function automatic logic is_lead(logic now, logic prev, logic rest);
        return (now != prev) && (now != rest);
    endfunction

    // A clock transition that returns to the rest level closes it.
    function automatic logic is_trail(logic now, logic prev, logic rest);
        return (now != prev) && (now == rest);
    endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int BRW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [BRW-1:0] br,
    output logic           tick
);
    localparam int CW = (1 << BRW) - 1;

    logic [CW:0]   span;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt;

    always_comb begin
        span  = {{CW{1'b0}}, 1'b1} << br;
        limit = CW'(span - 1'b1);
    end

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    AST_HALF_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= limit)); // R1

endmodule

// File: rtl/spi_sync2.sv
module spi_sync2 #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar g;
    for (g = 0; g < W; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= INIT[g];
                s2 <= INIT[g];
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] load_data,
    input  logic         lead,
    input  logic         trail,
    input  logic         sin,
    input  logic         lsb_first,
    input  logic         abort,
    output logic         sout,
    output logic         frame_end,
    output logic [N-1:0] rx_data,
    output logic         done
);
    localparam int            CW   = $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [N-1:0]  sh;
    logic [N-1:0]  sh_next;
    logic          samp;
    logic [CW-1:0] bit_cnt;

    assign sh_next   = lsb_first ? {samp, sh[N-1:1]} : {sh[N-2:0], samp};
    assign sout      = lsb_first ? sh[0] : sh[N-1];
    assign frame_end = trail && !abort && (bit_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            samp    <= 1'b0;
            bit_cnt <= '0;
            rx_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= frame_end;
            if (load)                 sh <= load_data;
            else if (trail && !abort) sh <= sh_next;
            if (lead && !abort) samp <= sin;
            if (abort)          bit_cnt <= '0;
            else if (trail)     bit_cnt <= frame_end ? '0 : bit_cnt + 1'b1;
            if (frame_end) rx_data <= sh_next;
        end
    end

    AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (rst)
        abort |=> (bit_cnt == '0)); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_frame_pkg::*;
#(
    parameter int N   = FRAME_BITS,
    parameter int BRW = BR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en_i,
    input  logic           master_i,
    input  logic           cpol_i,
    input  logic           lsb_first_i,
    input  logic [BRW-1:0] br_i,
    input  logic           rx_only_i,
    input  logic           ssm_i,
    input  logic           ssi_i,
    input  logic [N-1:0]   tx_data_i,
    input  logic           tx_load_i,
    input  logic           sck_i,
    output logic           sck_o,
    output logic           sck_oe_o,
    input  logic           mosi_i,
    output logic           mosi_o,
    output logic           mosi_oe_o,
    input  logic           miso_i,
    output logic           miso_o,
    output logic           miso_oe_o,
    input  logic           nss_i,
    output logic [N-1:0]   rx_data_o,
    output logic           done_o,
    output logic           busy_o
);
    cfg_t         cfg_now;
    cfg_t         cfg_l;
    logic         busy_q;
    logic         sck_lvl;
    logic         sck_prev;
    logic [2:0]   sync_q;
    logic         nss_s, sck_s, mosi_s;
    logic         nss_eff, slave_sel, abort;
    logic         s_lead, s_trail, m_lead, m_trail, m_start;
    logic         tick, lead, trail, sin, sout, frame_end, core_done;
    logic [N-1:0] tx_hold, tx_next, rx_q;

    always_comb begin
        cfg_now.master    = master_i;
        cfg_now.cpol      = cpol_i;
        cfg_now.lsb_first = lsb_first_i;
        cfg_now.rx_only   = rx_only_i;
        cfg_now.br        = br_i;
    end

    spi_sync2 #(.W(3), .INIT(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({nss_i, sck_i, mosi_i}),
        .q   (sync_q)
    );
    assign {nss_s, sck_s, mosi_s} = sync_q;

    // Select, abort and edge events
    assign nss_eff   = ssm_i ? ssi_i : nss_s;
    assign slave_sel = !cfg_l.master && !nss_eff && (en_i || busy_q);
    assign abort     = !cfg_l.master && nss_eff;
    assign s_lead    = slave_sel && is_lead(sck_s, sck_prev, cfg_l.cpol);
    assign s_trail   = slave_sel && busy_q && is_trail(sck_s, sck_prev, cfg_l.cpol);
    assign m_start   = tx_load_i && !busy_q && en_i && master_i;
    assign m_lead    = tick && (sck_lvl == cfg_l.cpol);
    assign m_trail   = tick && (sck_lvl != cfg_l.cpol);
    assign lead      = cfg_l.master ? m_lead  : s_lead;
    assign trail     = cfg_l.master ? m_trail : s_trail;
    assign sin       = cfg_l.master ? miso_i  : mosi_s;
    assign tx_next   = tx_load_i ? tx_data_i : tx_hold;

    spi_baud_gen #(.BRW(BRW)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_q && cfg_l.master),
        .br   (cfg_l.br),
        .tick (tick)
    );

    spi_shift_core #(.N(N)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (!busy_q),
        .load_data (tx_next),
        .lead      (lead),
        .trail     (trail),
        .sin       (sin),
        .lsb_first (cfg_l.lsb_first),
        .abort     (abort),
        .sout      (sout),
        .frame_end (frame_end),
        .rx_data   (rx_q),
        .done      (core_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_l    <= '0;
            busy_q   <= 1'b0;
            sck_lvl  <= 1'b0;
            sck_prev <= 1'b0;
            tx_hold  <= '0;
        end else begin
            sck_prev <= sck_s;
            if (!busy_q) begin
                cfg_l   <= cfg_now;
                sck_lvl <= cpol_i;
                if (tx_load_i) tx_hold <= tx_data_i;
            end else if (tick) begin
                sck_lvl <= !sck_lvl;
            end
            if (frame_end)    busy_q <= 1'b0;
            else if (m_start) busy_q <= 1'b1;
            else if (abort)   busy_q <= 1'b0;
            else if (s_lead)  busy_q <= 1'b1;
        end
    end

    // Pads
    assign sck_o     = sck_lvl;
    assign sck_oe_o  = cfg_l.master && (en_i || busy_q);
    assign mosi_o    = sout;
    assign mosi_oe_o = cfg_l.master && (en_i || busy_q) && !cfg_l.rx_only;
    assign miso_o    = sout;
    assign miso_oe_o = slave_sel && !cfg_l.rx_only;
    assign rx_data_o = rx_q;
    assign done_o    = core_done;
    assign busy_o    = busy_q;

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_q && $past(busy_q))); // R7

    AST_RXONLY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cfg_l.rx_only) |-> (!mosi_oe_o && !miso_oe_o)); // R4

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(cfg_l)); // R8

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (abort && !m_start) |=> !busy_q); // R6

endmodule

// File: tb/spi_frame_engine_bench.sv
module spi_frame_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, master = 0, cpol = 0, lsb = 0, rxo = 0, ssm = 0, ssi = 0;
    logic [2:0] br = 0;
    logic [7:0] txd = 0;
    logic txl = 0, sck_in = 0, mosi_in = 0, miso_in = 0, nss_in = 1;
    logic sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o, done_o, busy_o;
    logic [7:0] rx_data_o;

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int bcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_frame_engine u_spi_frame_engine (
        .clk(clk), .rst(rst), .en_i(en), .master_i(master), .cpol_i(cpol),
        .lsb_first_i(lsb), .br_i(br), .rx_only_i(rxo), .ssm_i(ssm), .ssi_i(ssi),
        .tx_data_i(txd), .tx_load_i(txl), .sck_i(sck_in), .sck_o(sck_o),
        .sck_oe_o(sck_oe_o), .mosi_i(mosi_in), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
        .miso_i(miso_in), .miso_o(miso_o), .miso_oe_o(miso_oe_o), .nss_i(nss_in),
        .rx_data_o(rx_data_o), .done_o(done_o), .busy_o(busy_o)
    );

    always @(negedge clk) begin
        if (done_o) done_cnt++;
        if (busy_o) bcnt++;
    end

    // {br, cpol, lsb_first, rx_only, tx word, word returned by the far end}
    localparam logic [21:0] VEC [7] = '{
        {3'd0, 1'b0, 1'b0, 1'b0, 8'h1D, 8'hB2},
        {3'd1, 1'b1, 1'b0, 1'b0, 8'h6E, 8'h0F},
        {3'd2, 1'b0, 1'b1, 1'b0, 8'h1D, 8'h35},
        {3'd3, 1'b1, 1'b1, 1'b0, 8'h80, 8'h01},
        {3'd0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h9C},
        {3'd7, 1'b0, 1'b1, 1'b0, 8'h4B, 8'hE1},
        {3'd1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h7A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // mode 0: plain, 1: disturb inputs mid-frame, 2: drop enable mid-frame
    task automatic m_xfer(input logic [21:0] v, input int mode);
        logic [2:0] vbr;
        logic vcpol, vlsb, vrxo, first, oe_any;
        logic [7:0] vtx, vsl, cap;
        {vbr, vcpol, vlsb, vrxo, vtx, vsl} = v;
        en = 1; master = 1; ssm = 0; nss_in = 1;
        cpol = vcpol; lsb = vlsb; br = vbr; rxo = vrxo; txd = vtx;
        miso_in = vlsb ? vsl[0] : vsl[7];
        cap = 0; first = 0; oe_any = 0;
        repeat (3) @(negedge clk);
        chk("R2 idle sck level", {31'd0, sck_o}, {31'd0, vcpol});
        chk("R2 idle sck enable", {31'd0, sck_oe_o}, 32'd1);
        bcnt = 0;
        txl = 1;
        @(negedge clk);
        txl = 0;
        for (int k = 0; k < 8; k++) begin
            @(sck_o);
            if (k == 0) first = mosi_o;
            cap = vlsb ? {mosi_o, cap[7:1]} : {cap[6:0], mosi_o};
            oe_any = oe_any | mosi_oe_o;
            if (k == 3 && mode == 1) begin
                txd = ~vtx; cpol = ~vcpol; lsb = ~vlsb; br = 3'd0; txl = 1;
                @(negedge clk);
                txl = 0;
            end
            if (k == 3 && mode == 2) en = 0;
            @(sck_o);
            if (k < 7) miso_in = vlsb ? vsl[k+1] : vsl[6-k];
        end
        @(negedge clk);
        chk("R7 done at frame end", {31'd0, done_o}, 32'd1);
        chk("R7 busy low at done", {31'd0, busy_o}, 32'd0);
        chk(mode == 1 ? "R8 rx word" : "R3 rx word", {24'd0, rx_data_o}, {24'd0, vsl});
        chk(mode == 1 ? "R8 busy length" : "R1 busy length", bcnt, 32'(16 << vbr));
        if (vrxo) begin
            chk("R4 mosi never enabled", {31'd0, oe_any}, 32'd0);
        end else begin
            chk(mode == 1 ? "R8 mosi word" : "R3 mosi word", {24'd0, cap}, {24'd0, vtx});
            chk("R3 first mosi bit", {31'd0, first}, {31'd0, vlsb ? vtx[0] : vtx[7]});
        end
        @(negedge clk);
        chk("R7 done one cycle", {31'd0, done_o}, 32'd0);
        if (mode == 2) begin
            chk("R9 frame finished after disable", {31'd0, sck_oe_o}, 32'd0);
            chk("R9 no drive after disable", {31'd0, mosi_oe_o}, 32'd0);
        end
    endtask

    task automatic s_prep(input logic cp, input logic l, input logic r,
                          input logic s_m, input logic s_i, input logic [7:0] tx);
        en = 1; master = 0; cpol = cp; lsb = l; rxo = r; ssm = s_m; ssi = s_i;
        sck_in = cp; nss_in = 1;
        repeat (4) @(negedge clk);
        txd = tx; txl = 1;
        @(negedge clk);
        txl = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic s_bits(input logic [7:0] w, input int n, input logic l, input logic cp,
                          output logic [7:0] cap, output logic oe_any);
        cap = 0; oe_any = 0;
        for (int k = 0; k < n; k++) begin
            logic b;
            b = l ? w[k] : w[7-k];
            mosi_in = b;
            repeat (H) @(negedge clk);
            cap = l ? {miso_o, cap[7:1]} : {cap[6:0], miso_o};
            oe_any = oe_any | miso_oe_o;
            sck_in = ~cp;
            repeat (H) @(negedge clk);
            sck_in = cp;
        end
        repeat (H) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R7 actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] cap;
        logic oe;
        int d0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R9 reset done", {31'd0, done_o}, 32'd0);
        chk("R9 reset busy", {31'd0, busy_o}, 32'd0);
        chk("R9 reset sck enable", {31'd0, sck_oe_o}, 32'd0);
        chk("R9 reset mosi enable", {31'd0, mosi_oe_o}, 32'd0);
        chk("R9 reset miso enable", {31'd0, miso_oe_o}, 32'd0);

        // Disabled master ignores the load strobe
        master = 1; en = 0; txd = 8'h55;
        repeat (2) @(negedge clk);
        txl = 1;
        @(negedge clk);
        txl = 0;
        repeat (4) @(negedge clk);
        chk("R9 no start while disabled", {31'd0, busy_o}, 32'd0);
        chk("R9 sck released while disabled", {31'd0, sck_oe_o}, 32'd0);

        for (int i = 0; i < 7; i++) m_xfer(VEC[i], 0);

        // Load and configuration changes mid-frame
        m_xfer({3'd2, 1'b0, 1'b0, 1'b0, 8'h5C, 8'hA3}, 1);
        // Enable dropped mid-frame
        m_xfer({3'd1, 1'b1, 1'b1, 1'b0, 8'h37, 8'h6D}, 2);

        // Slave, bit 7 first
        s_prep(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD4);
        nss_in = 0;
        repeat (H) @(negedge clk);
        d0 = done_cnt;
        s_bits(8'h3B, 8, 1'b0, 1'b0, cap, oe);
        repeat (2*H) @(negedge clk);
        chk("R10 slave rx word", {24'd0, rx_data_o}, 32'h3B);
        chk("R10 slave miso word", {24'd0, cap}, 32'hD4);
        chk("R10 slave one done", done_cnt - d0, 32'd1);
        nss_in = 1;

        // Slave, bit 0 first, clock rests high
        s_prep(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h19);
        nss_in = 0;
        repeat (H) @(negedge clk);
        s_bits(8'hC6, 8, 1'b1, 1'b1, cap, oe);
        repeat (2*H) @(negedge clk);
        chk("R3 slave lsb rx word", {24'd0, rx_data_o}, 32'hC6);
        chk("R3 slave lsb miso word", {24'd0, cap}, 32'h19);
        nss_in = 1;

        // Slave receive-only
        s_prep(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A);
        nss_in = 0;
        repeat (H) @(negedge clk);
        s_bits(8'h2E, 8, 1'b0, 1'b0, cap, oe);
        repeat (2*H) @(negedge clk);
        chk("R4 slave miso never enabled", {31'd0, oe}, 32'd0);
        chk("R4 slave rx while receive-only", {24'd0, rx_data_o}, 32'h2E);
        nss_in = 1;

        // Software select low, pin held high
        s_prep(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h71);
        s_bits(8'h94, 8, 1'b0, 1'b0, cap, oe);
        repeat (2*H) @(negedge clk);
        chk("R5 internal select used", {24'd0, rx_data_o}, 32'h94);
        chk("R5 internal select miso", {24'd0, cap}, 32'h71);

        // Software select high, pin held low
        s_prep(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0F);
        nss_in = 0;
        repeat (H) @(negedge clk);
        d0 = done_cnt;
        s_bits(8'hAA, 8, 1'b0, 1'b1, cap, oe);
        repeat (2*H) @(negedge clk);
        chk("R5 pin ignored no done", done_cnt - d0, 32'd0);
        chk("R5 pin ignored no miso drive", {31'd0, oe}, 32'd0);
        chk("R5 pin ignored rx kept", {24'd0, rx_data_o}, 32'h94);
        nss_in = 1; ssm = 0; ssi = 0;

        // Deselect mid-frame, then a full frame
        s_prep(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hB6);
        nss_in = 0;
        repeat (H) @(negedge clk);
        d0 = done_cnt;
        s_bits(8'hFF, 3, 1'b1, 1'b0, cap, oe);
        nss_in = 1;
        repeat (2*H) @(negedge clk);
        chk("R6 busy cleared by deselect", {31'd0, busy_o}, 32'd0);
        chk("R6 miso released by deselect", {31'd0, miso_oe_o}, 32'd0);
        chk("R6 no done on abort", done_cnt - d0, 32'd0);
        nss_in = 0;
        repeat (H) @(negedge clk);
        s_bits(8'h4D, 8, 1'b1, 1'b0, cap, oe);
        repeat (2*H) @(negedge clk);
        chk("R6 rx after abort", {24'd0, rx_data_o}, 32'h4D);
        chk("R6 miso after abort", {24'd0, cap}, 32'hB6);
        chk("R6 one done after abort", done_cnt - d0, 32'd1);
        nss_in = 1;

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule